// File: doc/BRIEF.md
# Edge-Latching Interrupt Aggregator

This block gathers a bank of edge-type interrupt sources into a single level request for a parent interrupt controller. A rising edge on any source input latches a pending bit. The pending bit stays set after the input falls, and it clears only when software acknowledges it. A per-source disable mask decides which pending bits may drive the summary output. Masked sources keep latching, so they raise the summary request as soon as they are re-enabled.

Software reaches the block over a plain synchronous register port. The port has a byte address, a write strobe with write data, and a read strobe with registered read data.

Both the pending bits and the mask have their own write-one-to-set and write-one-to-clear aliases. Software can therefore acknowledge, inject, enable or disable single sources without a read-modify-write. After reset nothing is pending and every source is disabled.

Top module: `irqagg_top`

## Requirements
- R1: The register map uses byte offsets, and bit n of every register belongs to source n:
  - 0x00: pending status.
  - 0x04: pending set.
  - 0x08: pending clear.
  - 0x0C: mask.
  - 0x10: mask set.
  - 0x14: mask clear.
- R2: Reset gives the following state:
  - Pending status is all zeros.
  - The mask is all ones, so every source is disabled.
  - The summary output is low.
  - Read data is zero.
- R3: A rising edge on a source input latches its pending bit. The bit stays 1 after the input returns low.
- R4: A write to 0x08 clears each pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged.
- R5: A write to 0x04 sets each pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged.
- R6: In the mask, a 1 disables the source. A write to 0x10 sets the mask bits whose write-data bit is 1. A write to 0x14 clears the mask bits whose write-data bit is 1. Zero bits in either write leave the mask unchanged.
- R7: The summary output is a register. It equals the OR of (pending AND NOT mask) as it stood one clock earlier.
- R8: A masked source still latches its pending bit. Clearing its mask bit then raises the summary output.
- R9: A rising edge and a clear write that hit the same bit in the same cycle leave that bit pending.
- R10: Reads and unmapped addresses behave as follows:
  - A read captures data one clock after the read strobe, and the read data holds until the next read.
  - Offsets 0x00, 0x04 and 0x08 return pending status.
  - Offsets 0x0C, 0x10 and 0x14 return the mask.
  - Any other address, including one that is not word aligned, reads as zero and ignores writes.
- R11: A source held high does not latch its pending bit again after that bit is cleared. Only a new rising edge sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | NUM_SRC (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | NUM_SRC (32) | Registered read data |
| src_i | input | NUM_SRC (32) | Interrupt source inputs, edge sensitive |
| irq_o | output | 1 | Level summary request to the parent controller |

## Verification
The bench builds the block with its default values: 32 sources and an 8-bit address. At 32 sources, the top bit of every register is exercised. The address range is wide enough to reach the unmapped word after the map and also a misaligned offset.

Directed sequences cover the following cases:
- Acknowledging a bit in the same cycle that its source rises.
- A source held high across a clear.
- Injection through the set alias while the source is masked.

A long random phase then mixes edges on many sources with writes to every alias and to unmapped addresses.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Byte offsets of the register words; software depends on these
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_SSET = 8'h04;
  localparam logic [7:0] OFF_SCLR = 8'h08;
  localparam logic [7:0] OFF_MASK = 8'h0C;
  localparam logic [7:0] OFF_MSET = 8'h10;
  localparam logic [7:0] OFF_MCLR = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_STAT = 3'd1,
    SEL_SSET = 3'd2,
    SEL_SCLR = 3'd3,
    SEL_MASK = 3'd4,
    SEL_MSET = 3'd5,
    SEL_MCLR = 3'd6
  } reg_sel_e;

endpackage

// File: rtl/irqagg_rstsync.sv
module irqagg_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[TOP];
endmodule

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] prev_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= src_i[i];
    end
    assign rise_o[i] = src_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_STAT)) sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFF_SSET)) sel_o = SEL_SSET;
    else if (addr_i == ADDR_W'(OFF_SCLR)) sel_o = SEL_SCLR;
    else if (addr_i == ADDR_W'(OFF_MASK)) sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFF_MSET)) sel_o = SEL_MSET;
    else if (addr_i == ADDR_W'(OFF_MCLR)) sel_o = SEL_MCLR;
  end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_sel_e           sel_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] st_set, st_clr, mk_set, mk_clr;
  logic               status_en, mask_en;

  always_comb begin
    st_set = (wr_en_i && sel_i == SEL_SSET) ? wdata_i : '0;
    st_clr = (wr_en_i && sel_i == SEL_SCLR) ? wdata_i : '0;
    mk_set = (wr_en_i && sel_i == SEL_MSET) ? wdata_i : '0;
    mk_clr = (wr_en_i && sel_i == SEL_MCLR) ? wdata_i : '0;
    // a fresh edge overrides an acknowledge of the same bit
    status_d  = (status_q | rise_i | st_set) & ~(st_clr & ~rise_i);
    mask_d    = (mask_q | mk_set) & ~mk_clr;
    status_en = (|rise_i) || (wr_en_i && (sel_i == SEL_SSET || sel_i == SEL_SCLR));
    mask_en   = wr_en_i && (sel_i == SEL_MSET || sel_i == SEL_MCLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      if (status_en) status_q <= status_d;
      if (mask_en)   mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr_en,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic               bus_rd_en,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic               rst_s_n;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] rd_mux, rdata_q;
  logic               irq_q, irq_d;

  irqagg_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  irqagg_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irqagg_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  irqagg_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sel_i    (sel),
    .wr_en_i  (bus_wr_en),
    .wdata_i  (bus_wdata),
    .rise_i   (rise),
    .status_o (status_q),
    .mask_o   (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT, SEL_SSET, SEL_SCLR: rd_mux = status_q;
      SEL_MASK, SEL_MSET, SEL_MCLR: rd_mux = mask_q;
      default:                      rd_mux = '0;
    endcase
    irq_d = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd_en) rdata_q <= rd_mux;
      irq_q <= irq_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [NUM_SRC-1:0] wdata,
  input logic [NUM_SRC-1:0] rise,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask,
  input logic               irq
);
  logic wr_sset, wr_sclr, wr_mset, wr_mclr;
  assign wr_sset = wr_en && (addr == ADDR_W'(OFF_SSET));
  assign wr_sclr = wr_en && (addr == ADDR_W'(OFF_SCLR));
  assign wr_mset = wr_en && (addr == ADDR_W'(OFF_MSET));
  assign wr_mclr = wr_en && (addr == ADDR_W'(OFF_MCLR));

  p_edge_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  p_pending_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sclr |=> ((~status & $past(status)) == '0));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sclr |=> ((status & $past(wdata & ~rise)) == '0));

  p_inject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sset |=> ((status & $past(wdata)) == $past(wdata)));

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask & $past(wdata)) == $past(wdata)));

  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(wdata)) == '0));

  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|($past(status) & ~$past(mask))));

  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sclr && |(rise & wdata)) |=> ((status & $past(rise & wdata)) == $past(rise & wdata)));

  p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mset || wr_mclr) |=> $stable(mask));
endmodule

bind irqagg_top irqagg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_s_n),
  .addr   (bus_addr),
  .wr_en  (bus_wr_en),
  .wdata  (bus_wdata),
  .rise   (rise),
  .status (status_q),
  .mask   (mask_q),
  .irq    (irq_o)
);

// File: tb/irqagg_top_test.sv
`timescale 1ns/1ps
module irqagg_top_test;
  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr_en;
  logic [N-1:0]  bus_wdata;
  logic          bus_rd_en;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  src_i;
  logic          irq_o;

  int vectors = 0;
  int errors  = 0;
  bit started = 0;
  bit done    = 0;

  // behavioural reference state
  logic [N-1:0] m_prev, m_stat, m_mask, m_rdata;
  logic         m_irq;

  always #2.5 clk = ~clk;

  irqagg_top #(.NUM_SRC(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o)
  );

  function automatic logic [N-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return m_stat;
      8'h0C, 8'h10, 8'h14: return m_mask;
      default:             return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] edges, ns, nm, nr;
    logic         ni;
    if (!rst_n) begin
      m_prev = '0; m_stat = '0; m_mask = '1; m_rdata = '0; m_irq = 1'b0;
    end else begin
      edges = src_i & ~m_prev;
      ns = m_stat | edges;
      nm = m_mask;
      if (bus_wr_en) begin
        if (bus_addr == 8'h04) ns = ns | bus_wdata;
        if (bus_addr == 8'h08) begin
          for (int b = 0; b < N; b++)
            if (bus_wdata[b] && !edges[b]) ns[b] = 1'b0;
        end
        if (bus_addr == 8'h10) nm = nm | bus_wdata;
        if (bus_addr == 8'h14) nm = nm & ~bus_wdata;
      end
      nr = bus_rd_en ? model_read(bus_addr) : m_rdata;
      ni = (m_stat & ~m_mask) != '0;
      m_prev = src_i; m_stat = ns; m_mask = nm; m_rdata = nr; m_irq = ni;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL R7 summary: got %0b expected %0b at %0t", irq_o, m_irq, $time);
      end
      vectors++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R10 read data: got %h expected %h at %0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    tick();
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    tick();
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr_en = 1'b0; bus_wdata = '0;
    bus_rd_en = 1'b0; src_i = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    started = 1;

    // R2 reset state
    rd(8'h00, d); check("R2 status after reset", d, 32'h0);
    rd(8'h0C, d); check("R2 mask after reset", d, 32'hFFFF_FFFF);
    check("R2 summary after reset", {31'd0, irq_o}, 32'h0);

    // R3 / R8 latch while masked
    src_i = 32'h8; tick(); src_i = '0; tick(); tick();
    rd(8'h00, d); check("R3 pending latched after pulse", d, 32'h8);
    check("R8 masked source keeps summary low", {31'd0, irq_o}, 32'h0);

    // R6 / R8 / R7 unmask raises summary one cycle later
    wr(8'h14, 32'h8);
    check("R7 summary not yet updated", {31'd0, irq_o}, 32'h0);
    tick();
    check("R8 unmask raises summary", {31'd0, irq_o}, 32'h1);

    // R4 zero bits no effect, then acknowledge
    wr(8'h08, 32'h0); tick();
    rd(8'h00, d); check("R4 zero clear keeps pending", d, 32'h8);
    wr(8'h08, 32'h8); tick();
    rd(8'h00, d); check("R4 acknowledge clears pending", d, 32'h0);
    check("R4 summary drops after ack", {31'd0, irq_o}, 32'h0);

    // R5 injection, R6 mask aliases
    wr(8'h04, 32'hA0); wr(8'h04, 32'h0);
    rd(8'h00, d); check("R5 injected pending bits", d, 32'hA0);
    wr(8'h14, 32'h20); tick();
    check("R6 mask clear enables source", {31'd0, irq_o}, 32'h1);
    wr(8'h10, 32'h20); tick();
    check("R6 mask set disables source", {31'd0, irq_o}, 32'h0);
    rd(8'h0C, d); check("R6 mask value", d, 32'hFFFF_FFF7);
    wr(8'h08, 32'hA0);

    // R9 edge and acknowledge in the same cycle
    src_i = 32'h80; wr(8'h08, 32'h80);
    rd(8'h00, d); check("R9 edge wins over clear", d, 32'h80);
    // R11 held-high source does not relatch
    wr(8'h08, 32'h80); tick();
    rd(8'h00, d); check("R11 held source not relatched", d, 32'h0);
    src_i = '0; tick();

    // R1 / R10 aliases and unmapped addresses
    wr(8'h04, 32'h8000_0011);
    rd(8'h04, d); check("R10 set alias reads status", d, 32'h8000_0011);
    rd(8'h08, d); check("R10 clear alias reads status", d, 32'h8000_0011);
    rd(8'h10, d); check("R10 mask set alias reads mask", d, 32'hFFFF_FFF7);
    rd(8'h14, d); check("R10 mask clear alias reads mask", d, 32'hFFFF_FFF7);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF); wr(8'h12, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R1 unmapped writes leave status", d, 32'h8000_0011);
    rd(8'h0C, d); check("R1 unmapped writes leave mask", d, 32'hFFFF_FFF7);
    rd(8'h18, d); check("R10 unmapped reads zero", d, 32'h0);
    tick();
    check("R10 read data holds", bus_rdata, 32'h0);

    // random mix compared each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      automatic int k = $urandom_range(0, 7);
      automatic logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h06};
      src_i     = $urandom() & $urandom();
      bus_addr  = addrs[k];
      bus_wdata = $urandom() & $urandom();
      bus_wr_en = ($urandom_range(0, 2) == 0);
      bus_rd_en = ($urandom_range(0, 1) == 0);
      tick();
    end
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; src_i = '0;
    repeat (3) tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule